// File: doc/BRIEF.md
# Continuously Variable Slope Delta Decoder

This block turns a serial delta-modulated bit stream back into signed PCM samples. Each time the data-clock strobe is seen, one received bit is taken in. Recent bits are kept in a short history. When the last three or four bits all agree, the slope is steep, and the step size grows. When they do not agree, the step size decays back towards its floor. A leaky integrator then adds or subtracts the current step. The step arithmetic and the integrator arithmetic are exact integer rules. Because of this, an encoder that uses the same rules keeps an internal estimate equal, bit for bit, to the samples produced here.

Two controls shape the stream. An active-low idle input replaces the received bits with an internal alternating pattern. This drives the output towards mid-scale, which is zero. A run-length select input picks three-bit or four-bit run detection. A power-enable input parks the whole decoder in its cleared state. Each processed bit produces one output sample, marked by a one-cycle valid pulse.

Top module: `cvsd_dec`

## Requirements
- R1: While reset is asserted and on leaving it, `sample_o` is 0, `valid_o` is 0 and the internal step equals `STEP_MIN`. A first bit of 1 after reset therefore yields a sample of exactly `+STEP_MIN`.
- R2: `valid_o` is high for exactly the one cycle after each clock edge at which `strobe_i` and `pwr_on_i` are both 1, and `sample_o` changes only in that cycle.
- R3: For each processed bit, the new sample is `acc - (acc >>> LEAK_SH) + step` for an effective bit of 1, or `acc - (acc >>> LEAK_SH) - step` for an effective bit of 0. Here `step` is the value after this bit's step update.
- R4: A run is declared when the newest 3 effective bits are all equal (`alg3_i`=1) or the newest 4 effective bits are all equal (`alg3_i`=0). The newest bit is included in the count.
- R5: A run can only be declared once at least the run length's number of bits have been processed since reset or power-up. Bits from before that point never count towards a run.
- R6: On a run, step becomes `min(step + STEP_INC, STEP_MIN*STEP_RATIO)`. Without a run, step becomes `max(step - (step >> DECAY_SH), STEP_MIN)`.
- R7: The sample saturates at `±(2^(SAMPLE_W-1)-1)` and never wraps.
- R8: While `idle_n_i` is 0, the effective bit is an internal alternating pattern. It is 0 on the first processed bit after reset or power-up, 1 on the second, and so on. The pattern advances on every processed bit. After 128 idle bits, `|sample_o|` is at most `2*STEP_MIN + 2^LEAK_SH`.
- R9: While `pwr_on_i` is 0, strobes are ignored, `valid_o` stays 0, and one cycle later the sample, step, history and idle pattern are back at their reset values.
- R10: While `idle_n_i` is 0, the value of `bit_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | One-cycle data-clock strobe; `bit_i` is taken at this edge |
| bit_i | input | 1 | Received delta bit (1 = slope up) |
| idle_n_i | input | 1 | 0 = substitute the alternating idle pattern |
| pwr_on_i | input | 1 | 0 = decoder held quiescent and cleared |
| alg3_i | input | 1 | 1 = three-bit run detection, 0 = four-bit |
| sample_o | output | SAMPLE_W | Signed reconstructed sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bench builds the decoder with a 10-bit sample, a step floor of 8, a 16:1 step ratio, a step increment of 16, a decay shift of 3 and a leak shift of 4. These small values let a run of ones push the integrator into saturation within a few dozen bits. They also let the step climb to its ceiling of 128 and fall back to its floor within one short scenario. With these values, the three-bit and four-bit run thresholds give different samples after only three or four bits, so both settings of the select input can be checked against exact hand-computed values.

// File: rtl/cvsd_dec_pkg.sv
package cvsd_dec_pkg;

  localparam int unsigned HIST_LEN = 4;

  typedef enum logic {
    RUN_LEN4 = 1'b0,
    RUN_LEN3 = 1'b1
  } run_len_e;

  // True when the lowest n bits of h are all equal.
  function automatic logic lows_agree(input logic [HIST_LEN-1:0] h, input int unsigned n);
    logic all0;
    logic all1;
    all0 = 1'b1;
    all1 = 1'b1;
    for (int unsigned i = 0; i < HIST_LEN; i++) begin
      if (i < n) begin
        all0 = all0 & ~h[i];
        all1 = all1 & h[i];
      end
    end
    return all0 | all1;
  endfunction

endpackage

// File: rtl/cvsd_run_det.sv
module cvsd_run_det
  import cvsd_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic bit_i,
  input  logic alg3_i,
  output logic run_o
);

  localparam int unsigned FILL_W = $clog2(HIST_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HIST_LEN);

  logic [HIST_LEN-1:0] hist_q, hist_d, hist_nx;
  logic [FILL_W-1:0]   fill_q, fill_d, fill_nx;
  logic [FILL_W-1:0]   need;
  run_len_e            mode;

  assign mode = run_len_e'(alg3_i);

  always_comb begin
    hist_nx = {hist_q[HIST_LEN-2:0], bit_i};
    fill_nx = (fill_q == FILL_FULL) ? fill_q : fill_q + 1'b1;
    need    = (mode == RUN_LEN3) ? FILL_W'(3) : FILL_W'(4);
    run_o   = en && (fill_nx >= need) &&
              lows_agree(hist_nx, (mode == RUN_LEN3) ? 3 : 4);
    hist_d  = hist_q;
    fill_d  = fill_q;
    if (clr) begin
      hist_d = '0;
      fill_d = '0;
    end else if (en) begin
      hist_d = hist_nx;
      fill_d = fill_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_FULL);

  p_run_needs_history_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (fill_q >= FILL_W'(2)));

  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0));

endmodule

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
  parameter int unsigned STEP_W   = 10,
  parameter int unsigned STEP_MIN = 32,
  parameter int unsigned STEP_MAX = 512,
  parameter int unsigned STEP_INC = 64,
  parameter int unsigned DECAY_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic              run_i,
  output logic [STEP_W-1:0] step_d_o
);

  localparam logic [STEP_W-1:0] MIN_V = STEP_W'(STEP_MIN);
  localparam logic [STEP_W-1:0] MAX_V = STEP_W'(STEP_MAX);
  localparam logic [STEP_W-1:0] INC_V = STEP_W'(STEP_INC);

  logic [STEP_W-1:0] step_q, step_d, grown, shrunk;

  always_comb begin
    grown = step_q + INC_V;
    if (grown > MAX_V) grown = MAX_V;
    shrunk = step_q - (step_q >> DECAY_SH);
    if (shrunk < MIN_V) shrunk = MIN_V;
    step_d = step_q;
    if (clr) begin
      step_d = MIN_V;
    end else if (en) begin
      step_d = run_i ? grown : shrunk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= MIN_V;
    else        step_q <= step_d;
  end

  assign step_d_o = step_d;

  p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= MIN_V) && (step_q <= MAX_V));

  p_step_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && run_i) |=> ((step_q > $past(step_q)) || (step_q == MAX_V)));

  p_step_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !run_i) |=> (step_q <= $past(step_q)));

endmodule

// File: rtl/cvsd_integ.sv
module cvsd_integ #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned STEP_W   = 10,
  parameter int unsigned LEAK_SH  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       clr,
  input  logic                       bit_i,
  input  logic [STEP_W-1:0]          step_i,
  output logic signed [SAMPLE_W-1:0] acc_o
);

  localparam int unsigned EW = SAMPLE_W + 2;
  localparam logic signed [EW-1:0] POS_LIM = {3'b000, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM;
  localparam logic [SAMPLE_W-1:0]  WRAP_V  = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] acc_q, acc_d;
  logic signed [EW-1:0]       acc_x, leak_x, step_x, sum_x, sat_x;

  always_comb begin
    acc_x  = {{2{acc_q[SAMPLE_W-1]}}, acc_q};
    leak_x = acc_x >>> LEAK_SH;
    step_x = {{(EW-STEP_W){1'b0}}, step_i};
    sum_x  = bit_i ? (acc_x - leak_x + step_x) : (acc_x - leak_x - step_x);
    if (sum_x > POS_LIM)      sat_x = POS_LIM;
    else if (sum_x < NEG_LIM) sat_x = NEG_LIM;
    else                      sat_x = sum_x;
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      acc_d = sat_x[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q != WRAP_V);

  p_rise_on_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && bit_i && (acc_q <= 0)) |=> (acc_q > $past(acc_q)));

  p_fall_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !bit_i && (acc_q >= 0)) |=> (acc_q < $past(acc_q)));

endmodule

// File: rtl/cvsd_dec.sv
module cvsd_dec #(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned STEP_MIN   = 32,
  parameter int unsigned STEP_RATIO = 16,
  parameter int unsigned STEP_INC   = 64,
  parameter int unsigned DECAY_SH   = 4,
  parameter int unsigned LEAK_SH    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe_i,
  input  logic                       bit_i,
  input  logic                       idle_n_i,
  input  logic                       pwr_on_i,
  input  logic                       alg3_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o
);

  localparam int unsigned STEP_MAX = STEP_MIN * STEP_RATIO;
  localparam int unsigned STEP_W   = $clog2(STEP_MAX + STEP_INC + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_q;
  logic              go, clr, eff_bit, run;
  logic              alt_q, alt_d, valid_d;
  logic [STEP_W-1:0] step_nx;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  always_comb begin
    go      = strobe_i & pwr_on_i;
    clr     = ~pwr_on_i;
    eff_bit = idle_n_i ? bit_i : alt_q;
    alt_d   = alt_q;
    if (clr)     alt_d = 1'b0;
    else if (go) alt_d = ~alt_q;
    valid_d = go;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      alt_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      alt_q   <= alt_d;
      valid_o <= valid_d;
    end
  end

  cvsd_run_det u_run (
    .clk    (clk),
    .rst_n  (rst_q),
    .en     (go),
    .clr    (clr),
    .bit_i  (eff_bit),
    .alg3_i (alg3_i),
    .run_o  (run)
  );

  cvsd_step_adapt #(
    .STEP_W   (STEP_W),
    .STEP_MIN (STEP_MIN),
    .STEP_MAX (STEP_MAX),
    .STEP_INC (STEP_INC),
    .DECAY_SH (DECAY_SH)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (go),
    .clr      (clr),
    .run_i    (run),
    .step_d_o (step_nx)
  );

  cvsd_integ #(
    .SAMPLE_W (SAMPLE_W),
    .STEP_W   (STEP_W),
    .LEAK_SH  (LEAK_SH)
  ) u_integ (
    .clk    (clk),
    .rst_n  (rst_q),
    .en     (go),
    .clr    (clr),
    .bit_i  (eff_bit),
    .step_i (step_nx),
    .acc_o  (sample_o)
  );

  p_valid_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !(strobe_i && pwr_on_i) |=> !valid_o);

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (pwr_on_i && !strobe_i) |=> $stable(sample_o));

  p_pwrdn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !pwr_on_i |=> ((sample_o == '0) && !valid_o));

endmodule

// File: tb/cvsd_dec_tb_top.sv
module cvsd_dec_tb_top;

  localparam int W    = 10;
  localparam int SMIN = 8;
  localparam int SRAT = 16;
  localparam int SINC = 16;
  localparam int DSH  = 3;
  localparam int LSH  = 4;
  localparam int SMAX = SMIN * SRAT;
  localparam int LIM  = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                rst_n, strobe, bit_in, idle_n, pwr_on, alg3;
  logic signed [W-1:0] sample;
  logic                valid;

  cvsd_dec #(
    .SAMPLE_W (W), .STEP_MIN (SMIN), .STEP_RATIO (SRAT),
    .STEP_INC (SINC), .DECAY_SH (DSH), .LEAK_SH (LSH)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .strobe_i (strobe), .bit_i (bit_in),
    .idle_n_i (idle_n), .pwr_on_i (pwr_on), .alg3_i (alg3),
    .sample_o (sample), .valid_o (valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int       m_acc, m_step, m_fill;
  logic [3:0] m_hist;
  logic     m_alt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    m_acc = 0; m_step = SMIN; m_fill = 0; m_hist = '0; m_alt = 1'b0;
  endtask

  task automatic m_bit(input logic b);
    logic eb, a0, a1, run;
    int n;
    eb = idle_n ? b : m_alt;
    m_alt = ~m_alt;
    m_hist = {m_hist[2:0], eb};
    if (m_fill < 4) m_fill++;
    n = alg3 ? 3 : 4;
    a0 = 1'b1; a1 = 1'b1;
    for (int i = 0; i < n; i++) begin
      a0 = a0 & ~m_hist[i];
      a1 = a1 & m_hist[i];
    end
    run = (m_fill >= n) && (a0 || a1);
    if (run) m_step = (m_step + SINC > SMAX) ? SMAX : m_step + SINC;
    else     m_step = (m_step - (m_step >> DSH) < SMIN) ? SMIN : m_step - (m_step >> DSH);
    m_acc = m_acc - (m_acc >>> LSH) + (eb ? m_step : -m_step);
    if (m_acc > LIM)  m_acc = LIM;
    if (m_acc < -LIM) m_acc = -LIM;
  endtask

  // Strobe one bit, then check valid and the sample in the following cycle.
  task automatic send(input logic b, input string tag);
    @(negedge clk);
    strobe = 1'b1; bit_in = b;
    m_bit(b);
    @(negedge clk);
    strobe = 1'b0;
    chk(valid === 1'b1, "R2", int'(valid), 1);
    chk($signed(sample) == m_acc, tag, int'($signed(sample)), m_acc);
  endtask

  task automatic power_cycle();
    @(negedge clk);
    pwr_on = 1'b0; strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sample == '0, "R9", int'($signed(sample)), 0);
    chk(valid === 1'b0, "R9", int'(valid), 0);
    strobe = 1'b0; pwr_on = 1'b1;
    m_clear();
  endtask

  task automatic t_reset();
    chk(sample == '0, "R1", int'($signed(sample)), 0);
    chk(valid === 1'b0, "R1", int'(valid), 0);
    alg3 = 1'b1;
    send(1'b1, "R1");
    chk($signed(sample) == SMIN, "R1", int'($signed(sample)), SMIN);
  endtask

  task automatic t_valid_r2();
    send(1'b0, "R3");
    @(negedge clk);
    chk(valid === 1'b0, "R2", int'(valid), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk($signed(sample) == m_acc, "R2", int'($signed(sample)), m_acc);
    end
  endtask

  task automatic t_run_len_r4();
    power_cycle();
    alg3 = 1'b1;
    for (int i = 0; i < 3; i++) send(1'b1, "R4");
    chk($signed(sample) == 39, "R4", int'($signed(sample)), 39);
    power_cycle();
    alg3 = 1'b0;
    for (int i = 0; i < 3; i++) send(1'b1, "R4");
    chk($signed(sample) == 23, "R4", int'($signed(sample)), 23);
    send(1'b1, "R4");
    chk($signed(sample) == 46, "R4", int'($signed(sample)), 46);
  endtask

  task automatic t_fill_r5();
    power_cycle();
    alg3 = 1'b1;
    send(1'b0, "R5");
    chk($signed(sample) == -SMIN, "R5", int'($signed(sample)), -SMIN);
    send(1'b0, "R5");
    send(1'b0, "R5");
  endtask

  task automatic t_sat_r7();
    int peak;
    power_cycle();
    alg3 = 1'b1;
    peak = 0;
    for (int i = 0; i < 60; i++) begin
      send(1'b1, "R7");
      if ($signed(sample) > peak) peak = $signed(sample);
    end
    chk(peak == LIM, "R7", peak, LIM);
    for (int i = 0; i < 60; i++) send(1'b0, "R7");
    chk($signed(sample) == -LIM, "R7", int'($signed(sample)), -LIM);
  endtask

  task automatic t_decay_r6();
    alg3 = 1'b0;
    for (int i = 0; i < 40; i++) send(logic'(i % 2), "R6");
    for (int i = 0; i < 12; i++) send(logic'((i / 2) % 2), "R6");
  endtask

  task automatic t_idle_r8();
    int mag;
    power_cycle();
    alg3 = 1'b1;
    for (int i = 0; i < 30; i++) send(1'b1, "R3");
    idle_n = 1'b0;
    for (int i = 0; i < 128; i++) send(logic'($urandom_range(1, 0)), "R10");
    mag = $signed(sample);
    if (mag < 0) mag = -mag;
    chk(mag <= 2 * SMIN + (1 << LSH), "R8", mag, 2 * SMIN + (1 << LSH));
    power_cycle();
    send(1'b1, "R8");
    chk($signed(sample) == -SMIN, "R8", int'($signed(sample)), -SMIN);
    idle_n = 1'b1;
  endtask

  task automatic t_pwr_r9();
    power_cycle();
    alg3 = 1'b1;
    send(1'b1, "R9");
    chk($signed(sample) == SMIN, "R9", int'($signed(sample)), SMIN);
  endtask

  initial begin
    rst_n = 1'b0; strobe = 1'b0; bit_in = 1'b0;
    idle_n = 1'b1; pwr_on = 1'b1; alg3 = 1'b1;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sample == '0, "R1", int'($signed(sample)), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_valid_r2();
    t_run_len_r4();
    t_fill_r5();
    t_sat_r7();
    t_decay_r6();
    t_idle_r8();
    t_pwr_r9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule